// File: doc/BRIEF.md
# Majority-Vote Register Read Sampler

This block stands in front of a register source whose reads are occasionally corrupted. When a requester asks for an address, the block reads that address once per cycle, many times in a row, and works out which value came back most often. That modal value is handed to the requester together with a one-cycle completion pulse. The requester never sees a single raw read.

Internally the block keeps a table of the distinct values seen during the current request, each with its occurrence count. It also tracks the entry with the highest count after every sample. Sampling ends at the earliest of two points. The first is as soon as one value has been seen more than half the maximum sample count. The second is when the maximum sample count has been reached. Ties go to the value that reached the leading count first.

The register source is modelled as a combinational read port. The block presents an address with a read strobe, and the data input is taken at the clock edge that ends that cycle.

Top module: `mvote_read_sampler`

## Requirements
- R1: After a synchronous active-low reset, `done_o` and `rd_en_o` are both low, and no read is issued until a request is accepted.
- R2: A request accepted while idle produces one read per cycle on consecutive cycles, each presenting the address given with the request. `rd_en_o` is low in the cycle in which `done_o` is high.
- R3: Each sample either increments the count of the matching table entry or, if no entry holds that value, adds a new entry with count 1. The result is the value with the highest count.
- R4: When two values share the highest count, the result is the one that reached that count first. A later value takes the lead only with a strictly greater count.
- R5: Sampling stops right after the sample that lifts the best count above MAX_SAMPLES/2 (integer division). For the default of 100, this is the sample that makes some value's count 51.
- R6: If no value passes that threshold, exactly MAX_SAMPLES reads are made.
- R7: `done_o` is high for exactly one cycle, the cycle after the edge that captured the last sample. `result_o` carries the result in that cycle and keeps it until the next completion.
- R8: The value table and best-entry tracking are cleared when each request is accepted. Values from earlier requests have no effect on the result or on the number of reads.
- R9: A request that arrives while sampling is running is ignored. The read address does not change, no extra completion occurs, and no new sampling run follows it.
- R10: No entry count exceeds MAX_SAMPLES, and the table never has to grow past its depth of MAX_SAMPLES entries.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| req_i | input | 1 | Read request, taken only while idle |
| req_addr_i | input | AW | Address for the request |
| rd_en_o | output | 1 | Read strobe toward the register source, one sample per cycle |
| rd_addr_o | output | AW | Address presented to the register source |
| rd_data_i | input | DW | Data from the register source, captured at the edge ending an `rd_en_o` cycle |
| done_o | output | 1 | One-cycle completion pulse |
| result_o | output | DW | Most frequent sampled value |

## Verification
The embedded properties check several things on every cycle. The completion pulse lasts one cycle. The read address holds steady through a run. The sample count never passes its cap. No entry count overflows and the table never runs out of space. The best count never falls within a run, and a tie never displaces the current best value. Only the bench scenarios can show that the returned value really is the mode, and that the early stop lands on the exact sample where a count first passes half. They also show the exact tie outcomes of alternating patterns, and that a new request is not influenced by the previous one. For these, the bench compares against an independently computed mode over the planned sample sequence.

// File: rtl/mvote_pkg.sv
// Package: shared types for the majority-vote read sampler.
// Assumes: nothing beyond IEEE 1800-2017.
package mvote_pkg;

    // Sequencer states: waiting for a request, or sampling.
    typedef enum logic {
        ST_IDLE = 1'b0,
        ST_RUN  = 1'b1
    } mvote_state_e;

endpackage

// File: rtl/mvote_value_table.sv
// Module: table of distinct sampled values with occurrence counts.
// Each written sample is compared against every occupied entry in parallel.
// A hit bumps that entry's count; a miss appends the value with count 1.
// Assumes: at most DEPTH samples are written between two clears.
module mvote_value_table #(
    parameter int DW    = 32,
    parameter int DEPTH = 100,
    parameter int CNT_W = $clog2(DEPTH + 1),
    parameter int IDX_W = (DEPTH > 1) ? $clog2(DEPTH) : 1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             clear_i,
    input  logic             we_i,
    input  logic [DW-1:0]    sample_i,
    output logic [CNT_W-1:0] new_cnt_o
);

    logic [DW-1:0]    vals [DEPTH];
    logic [CNT_W-1:0] cnts [DEPTH];
    logic [CNT_W-1:0] fill;
    logic [DEPTH-1:0] match;
    logic             hit;
    logic [IDX_W-1:0] hit_idx;
    logic [IDX_W-1:0] fill_idx;

    // Per-entry comparator: an entry matches only when occupied and equal.
    generate
        for (genvar g = 0; g < DEPTH; g++) begin : g_cmp
            assign match[g] = (CNT_W'(g) < fill) && (vals[g] == sample_i);
        end
    endgenerate

    // Reduce the match vector to a hit flag and the lowest matching index.
    always_comb begin
        hit     = 1'b0;
        hit_idx = '0;
        for (int i = DEPTH - 1; i >= 0; i--) begin
            if (match[i]) begin
                hit     = 1'b1;
                hit_idx = IDX_W'(i);
            end
        end
    end

    assign fill_idx  = IDX_W'(fill);
    // Count this sample's value will hold once written.
    assign new_cnt_o = hit ? (cnts[hit_idx] + CNT_W'(1)) : CNT_W'(1);

    // Occupancy counter: emptied on clear, grows on every miss.
    always_ff @(posedge clk) begin
        if (!rst_n || clear_i) begin
            fill <= '0;
        end else if (we_i && !hit) begin
            fill <= fill + CNT_W'(1);
        end
    end

    // Entry storage: bump the hit entry or append the new value.
    always_ff @(posedge clk) begin
        if (we_i) begin
            if (hit) begin
                cnts[hit_idx] <= new_cnt_o;
            end else begin
                vals[fill_idx] <= sample_i;
                cnts[fill_idx] <= CNT_W'(1);
            end
        end
    end

    // R10: a miss always finds a free slot.
    p_table_room_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (we_i && !hit) |-> (fill < CNT_W'(DEPTH)));

    // R10: an incremented count never passes the sample cap.
    p_no_overflow_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (we_i && hit) |-> (cnts[hit_idx] < CNT_W'(DEPTH)));

endmodule

// File: rtl/mvote_best_tracker.sv
// Module: keeps the value and count of the leading table entry.
// A new leader is taken only on a strictly greater count, so ties keep
// the earlier leader.
// Assumes: new_cnt_i is the post-update count of sample_i's entry.
module mvote_best_tracker #(
    parameter int DW    = 32,
    parameter int CNT_W = 7
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             clear_i,
    input  logic             upd_i,
    input  logic [DW-1:0]    sample_i,
    input  logic [CNT_W-1:0] new_cnt_i,
    output logic [CNT_W-1:0] best_cnt_nxt_o,
    output logic [DW-1:0]    best_val_nxt_o
);

    logic [CNT_W-1:0] best_cnt;
    logic [DW-1:0]    best_val;
    logic             takes_lead;

    // Lead changes only on a strictly greater count.
    assign takes_lead     = upd_i && (new_cnt_i > best_cnt);
    assign best_cnt_nxt_o = takes_lead ? new_cnt_i : best_cnt;
    assign best_val_nxt_o = takes_lead ? sample_i  : best_val;

    // Leader registers: cleared at request start, updated per sample.
    always_ff @(posedge clk) begin
        if (!rst_n || clear_i) begin
            best_cnt <= '0;
            best_val <= '0;
        end else begin
            best_cnt <= best_cnt_nxt_o;
            best_val <= best_val_nxt_o;
        end
    end

    // R4: within a run the leading count never falls.
    p_best_monotonic_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (upd_i && !clear_i) |=> (best_cnt >= $past(best_cnt)));

    // R4: a tie with the leader leaves the leading value in place.
    p_tie_keeps_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (upd_i && !clear_i && (new_cnt_i == best_cnt)) |=> (best_val == $past(best_val)));

endmodule

// File: rtl/mvote_ctrl.sv
// Module: request sequencer. It accepts a request while idle, issues one
// read per cycle, and ends on majority or on the sample cap. It then pulses
// done with the registered result.
// Assumes: best_*_nxt_i already include the sample of the current cycle.
module mvote_ctrl
    import mvote_pkg::*;
#(
    parameter int AW          = 16,
    parameter int DW          = 32,
    parameter int MAX_SAMPLES = 100,
    parameter int CNT_W       = 7
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             req_i,
    input  logic [AW-1:0]    req_addr_i,
    input  logic [CNT_W-1:0] best_cnt_nxt_i,
    input  logic [DW-1:0]    best_val_nxt_i,
    output logic             clear_o,
    output logic             rd_en_o,
    output logic [AW-1:0]    rd_addr_o,
    output logic             done_o,
    output logic [DW-1:0]    result_o
);

    localparam logic [CNT_W-1:0] LAST_N = CNT_W'(MAX_SAMPLES - 1);
    localparam logic [CNT_W-1:0] HALF_N = CNT_W'(MAX_SAMPLES / 2);

    mvote_state_e     state;
    logic [CNT_W-1:0] n_taken;
    logic             last;

    assign rd_en_o = (state == ST_RUN);
    assign clear_o = (state == ST_IDLE) && req_i;
    // Final sample: majority reached or cap hit.
    assign last    = rd_en_o && ((best_cnt_nxt_i > HALF_N) || (n_taken == LAST_N));

    // Sequencer: accept, count samples, finish with a registered result.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state     <= ST_IDLE;
            n_taken   <= '0;
            rd_addr_o <= '0;
            done_o    <= 1'b0;
            result_o  <= '0;
        end else begin
            done_o <= 1'b0;
            case (state)
                ST_IDLE: begin
                    if (req_i) begin
                        rd_addr_o <= req_addr_i;
                        n_taken   <= '0;
                        state     <= ST_RUN;
                    end
                end
                ST_RUN: begin
                    n_taken <= n_taken + CNT_W'(1);
                    if (last) begin
                        state    <= ST_IDLE;
                        done_o   <= 1'b1;
                        result_o <= best_val_nxt_i;
                    end
                end
                default: state <= ST_IDLE;
            endcase
        end
    end

    // R7: completion is a single-cycle pulse.
    p_done_pulse_r7: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |=> !done_o);

    // R2: no read is issued in the completion cycle.
    p_no_read_at_done_r2: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |-> !rd_en_o);

    // R9: the read address holds through a run despite new requests.
    p_addr_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_en_o && $past(rd_en_o)) |-> (rd_addr_o == $past(rd_addr_o)));

    // R6: the sample counter stays under the cap while reading.
    p_cap_r6: assert property (@(posedge clk) disable iff (!rst_n)
        rd_en_o |-> (n_taken < CNT_W'(MAX_SAMPLES)));

endmodule

// File: rtl/mvote_read_sampler.sv
// Module: top of the majority-vote read sampler. It joins the sequencer,
// the value table and the leader tracker.
// Assumes: rd_data_i is valid at the clock edge ending each rd_en_o cycle.
module mvote_read_sampler #(
    parameter int AW          = 16,
    parameter int DW          = 32,
    parameter int MAX_SAMPLES = 100
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          req_i,
    input  logic [AW-1:0] req_addr_i,
    output logic          rd_en_o,
    output logic [AW-1:0] rd_addr_o,
    input  logic [DW-1:0] rd_data_i,
    output logic          done_o,
    output logic [DW-1:0] result_o
);

    localparam int CNT_W = $clog2(MAX_SAMPLES + 1);

    logic             clear;
    logic [CNT_W-1:0] new_cnt;
    logic [CNT_W-1:0] best_cnt_nxt;
    logic [DW-1:0]    best_val_nxt;

    mvote_ctrl #(
        .AW(AW), .DW(DW), .MAX_SAMPLES(MAX_SAMPLES), .CNT_W(CNT_W)
    ) u_ctrl (
        .clk(clk), .rst_n(rst_n),
        .req_i(req_i), .req_addr_i(req_addr_i),
        .best_cnt_nxt_i(best_cnt_nxt), .best_val_nxt_i(best_val_nxt),
        .clear_o(clear), .rd_en_o(rd_en_o), .rd_addr_o(rd_addr_o),
        .done_o(done_o), .result_o(result_o)
    );

    mvote_value_table #(
        .DW(DW), .DEPTH(MAX_SAMPLES), .CNT_W(CNT_W)
    ) u_table (
        .clk(clk), .rst_n(rst_n),
        .clear_i(clear), .we_i(rd_en_o), .sample_i(rd_data_i),
        .new_cnt_o(new_cnt)
    );

    mvote_best_tracker #(
        .DW(DW), .CNT_W(CNT_W)
    ) u_best (
        .clk(clk), .rst_n(rst_n),
        .clear_i(clear), .upd_i(rd_en_o), .sample_i(rd_data_i),
        .new_cnt_i(new_cnt),
        .best_cnt_nxt_o(best_cnt_nxt), .best_val_nxt_o(best_val_nxt)
    );

endmodule

// File: tb/tb_mvote_read_sampler.sv
module tb_mvote_read_sampler;

    localparam int AW = 16;
    localparam int DW = 32;
    localparam int NS = 100;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          req = 1'b0;
    logic [AW-1:0] req_addr = '0;
    logic          rd_en;
    logic [AW-1:0] rd_addr;
    logic [DW-1:0] rd_data;
    logic          done;
    logic [DW-1:0] result;

    logic [DW-1:0] seq [NS];
    int            src_idx = 0;
    logic          src_clr = 1'b0;
    int            n_checks = 0;
    int            n_errors = 0;

    always #2 clk = ~clk;  // 250 MHz

    mvote_read_sampler #(.AW(AW), .DW(DW), .MAX_SAMPLES(NS)) dut (
        .clk(clk), .rst_n(rst_n), .req_i(req), .req_addr_i(req_addr),
        .rd_en_o(rd_en), .rd_addr_o(rd_addr), .rd_data_i(rd_data),
        .done_o(done), .result_o(result)
    );

    // Register source model: serves the planned sequence, one entry per read.
    assign rd_data = (src_idx < NS) ? seq[src_idx] : '0;
    always @(posedge clk) begin
        if (src_clr) src_idx <= 0;
        else if (rd_en) src_idx <= src_idx + 1;
    end

    task automatic check(input bit ok, input string rq, input string what,
                         input longint act, input longint exp);
        n_checks++;
        if (!ok) begin
            n_errors++;
            $display("FAIL %s %s: actual %0h expected %0h", rq, what, act, exp);
        end
    endtask

    // Reference mode with early stop and first-to-lead tie rule.
    function automatic void ref_mode(output logic [DW-1:0] val, output int used);
        logic [DW-1:0] v [NS];
        int c [NS];
        int fill = 0, bi = 0, bc = 0;
        used = NS;
        for (int i = 0; i < NS; i++) begin
            int j = fill;
            for (int k = 0; k < fill; k++) if (v[k] == seq[i] && j == fill) j = k;
            if (j == fill) begin v[j] = seq[i]; c[j] = 1; fill++; end
            else c[j]++;
            if (c[j] > bc) begin bc = c[j]; bi = j; end
            if (bc > NS / 2) begin used = i + 1; break; end
        end
        val = v[bi];
    endfunction

    // Issue one request, observe reads and completion, compare to reference.
    task automatic run_req(input logic [AW-1:0] a, input int inject_at, input string rq);
        logic [DW-1:0] ev;
        int eu, n = 0, cyc = 0, dones = 0, bad_addr = 0;
        logic [DW-1:0] got = '0;
        ref_mode(ev, eu);
        @(negedge clk); src_clr = 1'b1;
        @(negedge clk); src_clr = 1'b0; req = 1'b1; req_addr = a;
        while (dones == 0 && cyc < 400) begin
            @(negedge clk);
            if (rd_en) begin n++; if (rd_addr !== a) bad_addr++; end
            if (done) begin dones++; got = result; end
            req = (inject_at > 0 && cyc == inject_at);
            if (req) req_addr = ~a;
            cyc++;
        end
        req = 1'b0;
        check(dones == 1, rq, "completion seen (watchdog)", dones, 1);
        check(bad_addr == 0, "R2/R9", "read address mismatches", bad_addr, 0);
        check(got == ev, rq, "result value", got, ev);
        check(n == eu, rq, "number of reads", n, eu);
        @(negedge clk);
        check(done == 1'b0, "R7", "done after one cycle", done, 0);
        check(rd_en == 1'b0, "R9", "no restart after completion", rd_en, 0);
        check(result == got, "R7", "result held", result, got);
    endtask

    initial begin
        void'($urandom(32'd20240611));
        for (int i = 0; i < NS; i++) seq[i] = '0;
        repeat (3) @(negedge clk);
        check(done == 1'b0, "R1", "done in reset", done, 0);
        check(rd_en == 1'b0, "R1", "rd_en in reset", rd_en, 0);
        rst_n = 1'b1;
        repeat (3) @(negedge clk);
        check(rd_en == 1'b0, "R1", "no read without request", rd_en, 0);

        // R5: constant source stops at count 51.
        for (int i = 0; i < NS; i++) seq[i] = 32'hCAFE_0001;
        run_req(16'h0010, 0, "R5");

        // R8: all distinct after a majority run; expect first sample, 100 reads.
        for (int i = 0; i < NS; i++) seq[i] = 32'h1000_0000 + i;
        run_req(16'h0020, 0, "R8");

        // R4: alternating A/B ties at 50; A reached 50 first.
        for (int i = 0; i < NS; i++) seq[i] = (i % 2 == 0) ? 32'hAAAA : 32'hBBBB;
        run_req(16'h0030, 0, "R4");

        // R4: B then A alternation, 49 B's before A leads? B first to 50.
        for (int i = 0; i < NS; i++) seq[i] = (i % 2 == 0) ? 32'hBBBB : 32'hAAAA;
        run_req(16'h0031, 0, "R4");

        // R5: majority reached on the very last sample (count 51 at read 100).
        for (int i = 0; i < NS; i++) seq[i] = (i < 49) ? 32'h2000_0000 + i : 32'h5151;
        run_req(16'h0040, 0, "R5");

        // R6: 50 copies only, no majority; full run, mode is that value.
        for (int i = 0; i < NS; i++) seq[i] = (i % 2 == 1) ? 32'h3000_0000 + i : 32'h5050;
        run_req(16'h0050, 0, "R6");

        // R9: request injected mid-run is ignored.
        for (int i = 0; i < NS; i++) seq[i] = 32'h9999;
        run_req(16'h0060, 7, "R9");

        // R3: random noisy sources with a dominant value.
        for (int t = 0; t < 20; t++) begin
            logic [DW-1:0] dom = $urandom;
            int pct = 30 + int'($urandom % 61);
            for (int i = 0; i < NS; i++)
                seq[i] = (int'($urandom % 100) < pct) ? dom : (dom ^ (32'h1 << ($urandom % 3)));
            run_req(AW'($urandom), (t % 4 == 0) ? 3 : 0, "R3");
        end

        $display("Simulation finished: %0d checks, %0d errors", n_checks, n_errors);
        $finish;
    end

    // Global watchdog: a hung run is a failed check.
    initial begin
        repeat (150000) @(posedge clk);
        n_checks++; n_errors++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("Simulation finished: %0d checks, %0d errors", n_checks, n_errors);
        $finish;
    end

endmodule